// File: doc/BRIEF.md
# Three-Port Parallel I/O Interface

This block gives a processor three 8-bit parallel ports, called A, B and C, behind a small register bus. The bus has a 2-bit address, a chip select, single-cycle active-high read and write strobes, and 8-bit write and read data. Each port pin is modelled as three signals: an input level, an output level and an output enable. A control byte written at the top address can do one of two things. It can configure the port groups, choosing simple latched I/O or strobed handshake I/O and setting the direction of each port. Or it can set or clear one port C bit without disturbing anything else.

In handshake operation, port A (group A) and port B (group B) each have a channel of flag logic. That logic takes over fixed port C pins. Those pins carry the device strobe or acknowledge into the block, and carry the buffer-full and interrupt-request flags out of it. Read data is registered: it appears on `rdata` one clock after the read strobe. The bidirectional bus mode is not supported. A group A mode field of binary 1x is treated as simple I/O.

Top module: `tri_port_pio`

## Requirements
- R1: After reset, every output enable is 0, every output level is 0, `rdata` is 0x00, and the control byte reads back as 0x9B (every port an input, both groups in simple I/O).
- R2: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control byte. A configuration word reads back as {1, 0, A handshake, A input, C-upper input, B handshake, B input, C-lower input}. A group A mode field of 1x reads back as 0 and behaves as simple I/O.
- R3: A control write with bit 7 set configures the ports. In that word, bits 6:5 hold the group A mode (01 = handshake), bit 2 the group B mode, bit 4 the port A direction, bit 1 the port B direction, bit 3 the C-upper direction and bit 0 the C-lower direction, where 1 means input. 0x80 makes every port an output. A write to an output port appears on its output level the clock after the strobe, and reads back from the latch.
- R4: In simple I/O, reading an input port returns the live pin levels, with no latching.
- R5: Each nibble of port C follows its own direction bit. A read of port C returns pin levels for input bits and latch values for output bits.
- R6: A control write with bit 7 clear sets port C latch bit wdata[3:1] to wdata[0] and leaves the configuration unchanged.
- R7: A configuration write clears the A, B and C output latches and all handshake flags.
- R8: Group A handshake input: while strobe pin C4 is low, port A is loaded into an input latch and buffer-full pin C5 goes high. A rising edge on C4 while buffer-full is set raises interrupt pin C3. A port A read returns the latched value and clears C5 and C3.
- R9: Group A handshake output: a port A write drives buffer-full pin C7 low and clears interrupt pin C3. A falling edge on acknowledge pin C6 returns C7 high. A rising edge on C6 raises C3.
- R10: Group B handshake uses C2 as its strobe or acknowledge input, C1 as its buffer-full flag and C0 as its interrupt. The flags behave as in R8 (input) and R9 (output).
- R11: In handshake operation, the strobe or acknowledge pin has its output enable at 0 and the flag pins have theirs at 1, whatever the nibble direction bits say.
- R12: Strobes given while chip select is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, one cycle |
| wr | input | 1 | Write strobe, one cycle |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output levels |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output levels |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output levels |
| pc_oe | output | 8 | Port C output enables |

## Verification
The properties rely on four assumptions about the inputs. Read and write strobes are never raised together. A configuration write never lands in the same cycle as a strobe or acknowledge edge. Handshake pins are levels that change at most once per clock. A port read never coincides with the start of a new strobe it is meant to race. The stimulus meets these assumptions in two ways. It changes every input on the falling clock edge. And it gives each bus access, strobe edge and acknowledge edge a clock cycle of its own, so that no two events share an edge.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2;
  localparam int IDX_W  = $clog2(BYTE_W);

  typedef enum logic [ADDR_W-1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CTL = 2'd3
  } pio_sel_e;

  typedef struct packed {
    logic a_hs;
    logic a_in;
    logic cu_in;
    logic b_hs;
    logic b_in;
    logic cl_in;
  } pio_cfg_t;

  localparam pio_cfg_t CFG_RESET = '{a_hs: 1'b0, a_in: 1'b1, cu_in: 1'b1,
                                     b_hs: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  // port C pin roles in handshake operation
  localparam int PC_A_INTR = 3;
  localparam int PC_A_STB  = 4;
  localparam int PC_A_IBF  = 5;
  localparam int PC_A_ACK  = 6;
  localparam int PC_A_OBF  = 7;
  localparam int PC_B_INTR = 0;
  localparam int PC_B_FLAG = 1;
  localparam int PC_B_HS   = 2;
endpackage

// File: rtl/pio_ctrl_reg.sv
module pio_ctrl_reg
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [BYTE_W-1:0] wdata,
  output pio_cfg_t          cfg,
  output logic              mode_wr,
  output logic              bsr_wr,
  output logic [IDX_W-1:0]  bsr_idx,
  output logic              bsr_val,
  output logic [BYTE_W-1:0] ctl_rd
);
  // top bit of the control byte picks the meaning of the rest
  assign mode_wr = ctl_wr &  wdata[BYTE_W-1];
  assign bsr_wr  = ctl_wr & ~wdata[BYTE_W-1];
  assign bsr_idx = wdata[IDX_W:1];
  assign bsr_val = wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_RESET;
    end else if (mode_wr) begin
      cfg.a_hs  <= ~wdata[6] & wdata[5];  // 1x falls back to simple I/O
      cfg.a_in  <= wdata[4];
      cfg.cu_in <= wdata[3];
      cfg.b_hs  <= wdata[2];
      cfg.b_in  <= wdata[1];
      cfg.cl_in <= wdata[0];
    end
  end

  assign ctl_rd = {1'b1, 1'b0, cfg.a_hs, cfg.a_in, cfg.cu_in,
                   cfg.b_hs, cfg.b_in, cfg.cl_in};
endmodule

// File: rtl/pio_hs_chan.sv
module pio_hs_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,       // group in handshake operation
  input  logic         dir_in,   // 1: input channel, 0: output channel
  input  logic         clr,      // configuration write
  input  logic         pin_hs,   // strobe (input) or acknowledge (output), active low
  input  logic [W-1:0] pin_data,
  input  logic         cpu_rd,
  input  logic         cpu_wr,
  output logic [W-1:0] in_lat,
  output logic         flag,     // input: buffer full high; output: buffer full low
  output logic         intr
);
  logic hs_q;
  logic full;
  logic hs_rise, hs_fall;

  assign hs_rise = ~hs_q &  pin_hs;
  assign hs_fall =  hs_q & ~pin_hs;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q   <= 1'b1;
      full   <= 1'b0;
      intr   <= 1'b0;
      in_lat <= '0;
    end else begin
      hs_q <= pin_hs;
      if (clr || !en) begin
        full <= 1'b0;
        intr <= 1'b0;
        if (clr) in_lat <= '0;
      end else if (dir_in) begin
        if (cpu_rd) begin
          full <= 1'b0;
          intr <= 1'b0;
        end
        if (!pin_hs) begin
          in_lat <= pin_data;
          full   <= 1'b1;
        end
        if (hs_rise && full) intr <= 1'b1;
      end else begin
        if (cpu_wr) begin
          full <= 1'b1;
          intr <= 1'b0;
        end
        if (hs_fall) full <= 1'b0;
        if (hs_rise) intr <= 1'b1;
      end
    end
  end

  assign flag = dir_in ? full : ~full;
endmodule

// File: rtl/tri_port_pio.sv
module tri_port_pio
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic [BYTE_W-1:0] pa_in,
  output logic [BYTE_W-1:0] pa_out,
  output logic [BYTE_W-1:0] pa_oe,
  input  logic [BYTE_W-1:0] pb_in,
  output logic [BYTE_W-1:0] pb_out,
  output logic [BYTE_W-1:0] pb_oe,
  input  logic [BYTE_W-1:0] pc_in,
  output logic [BYTE_W-1:0] pc_out,
  output logic [BYTE_W-1:0] pc_oe
);
  localparam int NIB_W = BYTE_W / 2;

  logic rd_hit, wr_hit;
  logic wr_a, wr_b, wr_c, wr_ctl, rd_a, rd_b;
  assign rd_hit = cs & rd;
  assign wr_hit = cs & wr;
  assign wr_a   = wr_hit && (addr == SEL_A);
  assign wr_b   = wr_hit && (addr == SEL_B);
  assign wr_c   = wr_hit && (addr == SEL_C);
  assign wr_ctl = wr_hit && (addr == SEL_CTL);
  assign rd_a   = rd_hit && (addr == SEL_A);
  assign rd_b   = rd_hit && (addr == SEL_B);

  pio_cfg_t          cfg_q;
  logic              mode_wr, bsr_wr, bsr_val;
  logic [IDX_W-1:0]  bsr_idx;
  logic [BYTE_W-1:0] ctl_rd;

  pio_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .ctl_wr(wr_ctl), .wdata(wdata), .cfg(cfg_q),
    .mode_wr(mode_wr), .bsr_wr(bsr_wr), .bsr_idx(bsr_idx),
    .bsr_val(bsr_val), .ctl_rd(ctl_rd)
  );

  // output latches
  logic [BYTE_W-1:0] a_lat, b_lat, c_lat;
  always_ff @(posedge clk) begin
    if (rst || mode_wr) begin
      a_lat <= '0;
      b_lat <= '0;
      c_lat <= '0;
    end else begin
      if (wr_a) a_lat <= wdata;
      if (wr_b) b_lat <= wdata;
      if (wr_c) c_lat <= wdata;
      else if (bsr_wr) c_lat[bsr_idx] <= bsr_val;
    end
  end

  // handshake channels
  logic [BYTE_W-1:0] a_inl, b_inl;
  logic a_flag, a_intr, b_flag, b_intr;

  pio_hs_chan #(.W(BYTE_W)) u_hs_a (
    .clk(clk), .rst(rst), .en(cfg_q.a_hs), .dir_in(cfg_q.a_in), .clr(mode_wr),
    .pin_hs(cfg_q.a_in ? pc_in[PC_A_STB] : pc_in[PC_A_ACK]),
    .pin_data(pa_in), .cpu_rd(rd_a), .cpu_wr(wr_a),
    .in_lat(a_inl), .flag(a_flag), .intr(a_intr)
  );

  pio_hs_chan #(.W(BYTE_W)) u_hs_b (
    .clk(clk), .rst(rst), .en(cfg_q.b_hs), .dir_in(cfg_q.b_in), .clr(mode_wr),
    .pin_hs(pc_in[PC_B_HS]),
    .pin_data(pb_in), .cpu_rd(rd_b), .cpu_wr(wr_b),
    .in_lat(b_inl), .flag(b_flag), .intr(b_intr)
  );

  // port A and B pins
  assign pa_out = a_lat;
  assign pb_out = b_lat;
  assign pa_oe  = {BYTE_W{~cfg_q.a_in}};
  assign pb_oe  = {BYTE_W{~cfg_q.b_in}};

  // port C pins: nibble directions, then handshake roles on top
  always_comb begin
    pc_out = c_lat;
    pc_oe  = {{NIB_W{~cfg_q.cu_in}}, {NIB_W{~cfg_q.cl_in}}};
    if (cfg_q.b_hs) begin
      pc_out[PC_B_INTR] = b_intr;
      pc_oe[PC_B_INTR]  = 1'b1;
      pc_out[PC_B_FLAG] = b_flag;
      pc_oe[PC_B_FLAG]  = 1'b1;
      pc_oe[PC_B_HS]    = 1'b0;
    end
    if (cfg_q.a_hs) begin
      pc_out[PC_A_INTR] = a_intr;
      pc_oe[PC_A_INTR]  = 1'b1;
      if (cfg_q.a_in) begin
        pc_out[PC_A_IBF] = a_flag;
        pc_oe[PC_A_IBF]  = 1'b1;
        pc_oe[PC_A_STB]  = 1'b0;
      end else begin
        pc_out[PC_A_OBF] = a_flag;
        pc_oe[PC_A_OBF]  = 1'b1;
        pc_oe[PC_A_ACK]  = 1'b0;
      end
    end
  end

  // read path
  logic [BYTE_W-1:0] a_rd, b_rd, c_rd;
  assign a_rd = cfg_q.a_in ? (cfg_q.a_hs ? a_inl : pa_in) : a_lat;
  assign b_rd = cfg_q.b_in ? (cfg_q.b_hs ? b_inl : pb_in) : b_lat;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_c_rd
    assign c_rd[i] = pc_oe[i] ? pc_out[i] : pc_in[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_hit) begin
      unique case (addr)
        SEL_A:   rdata <= a_rd;
        SEL_B:   rdata <= b_rd;
        SEL_C:   rdata <= c_rd;
        default: rdata <= ctl_rd;
      endcase
    end
  end
endmodule

// File: rtl/pio_port_checks.sv
module pio_port_checks
  import pio_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cs,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [BYTE_W-1:0] wdata,
  input logic [BYTE_W-1:0] rdata,
  input logic [BYTE_W-1:0] pa_out,
  input logic [BYTE_W-1:0] pb_out,
  input logic [BYTE_W-1:0] pc_in,
  input logic [BYTE_W-1:0] pc_out,
  input pio_cfg_t          cfg
);
  a_r1_rdata_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> rdata == '0);

  a_r3_latch_write: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == SEL_A) |=> pa_out == $past(wdata));

  a_r6_bsr_keeps_cfg: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == SEL_CTL && !wdata[BYTE_W-1]) |=> $stable(cfg));

  a_r8_ibf_on_strobe: assert property (@(posedge clk) disable iff (rst)
    (cfg.a_hs && cfg.a_in && !pc_in[PC_A_STB] && !(cs && wr && addr == SEL_CTL))
      |=> pc_out[PC_A_IBF]);

  a_r9_obf_on_write: assert property (@(posedge clk) disable iff (rst)
    (cfg.a_hs && !cfg.a_in && cs && wr && addr == SEL_A && pc_in[PC_A_ACK])
      |=> !pc_out[PC_A_OBF]);

  a_r12_no_select: assert property (@(posedge clk) disable iff (rst)
    !cs |=> $stable(pa_out) && $stable(pb_out));
endmodule

bind tri_port_pio pio_port_checks chk_i (
  .clk(clk), .rst(rst), .cs(cs), .wr(wr), .addr(addr), .wdata(wdata),
  .rdata(rdata), .pa_out(pa_out), .pb_out(pb_out), .pc_in(pc_in),
  .pc_out(pc_out), .cfg(cfg_q)
);

// File: tb/tri_port_pio_tb_top.sv
`timescale 1ns/1ps
module tri_port_pio_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'hFF;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  tri_port_pio dut_i (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  // {rd, chk, addr, wdata, pa/pb pins, pc pins, expected, req}
  localparam int NV = 27;
  localparam logic [39:0] VEC [NV] = '{
    {1'b0,1'b0,2'd3,8'h80,8'h00,8'h00,8'h00,4'd3},  // R3 all outputs
    {1'b0,1'b1,2'd0,8'h55,8'h00,8'h00,8'h55,4'd3},  // R3
    {1'b0,1'b1,2'd1,8'hAA,8'h00,8'h00,8'hAA,4'd3},  // R3
    {1'b0,1'b1,2'd2,8'h3C,8'h00,8'h00,8'h3C,4'd3},  // R3
    {1'b1,1'b1,2'd3,8'h00,8'h00,8'h00,8'h80,4'd2},  // R2
    {1'b1,1'b1,2'd0,8'h00,8'hFF,8'h00,8'h55,4'd3},  // R3 latch readback
    {1'b0,1'b0,2'd3,8'h9B,8'h00,8'h00,8'h00,4'd4},  // all inputs
    {1'b1,1'b1,2'd0,8'h00,8'hC3,8'h00,8'hC3,4'd4},  // R4
    {1'b1,1'b1,2'd1,8'h00,8'h5A,8'h00,8'h5A,4'd4},  // R4
    {1'b1,1'b1,2'd2,8'h00,8'h00,8'h96,8'h96,4'd4},  // R4
    {1'b0,1'b0,2'd3,8'h88,8'h00,8'h00,8'h00,4'd5},  // C upper in, lower out
    {1'b0,1'b1,2'd2,8'h0F,8'h00,8'h00,8'h0F,4'd5},  // R5
    {1'b1,1'b1,2'd2,8'h00,8'h00,8'hA5,8'hAF,4'd5},  // R5 mixed read
    {1'b1,1'b1,2'd3,8'h00,8'h00,8'h00,8'h88,4'd2},  // R2
    {1'b0,1'b0,2'd3,8'hC0,8'h00,8'h00,8'h00,4'd2},  // mode field 1x
    {1'b1,1'b1,2'd3,8'h00,8'h00,8'h00,8'h80,4'd2},  // R2 falls back
    {1'b0,1'b0,2'd3,8'h07,8'h00,8'h00,8'h00,4'd6},  // set bit 3
    {1'b1,1'b1,2'd2,8'h00,8'h00,8'h00,8'h08,4'd6},  // R6
    {1'b0,1'b0,2'd3,8'h0F,8'h00,8'h00,8'h00,4'd6},  // set bit 7
    {1'b1,1'b1,2'd2,8'h00,8'h00,8'h00,8'h88,4'd6},  // R6
    {1'b0,1'b0,2'd3,8'h06,8'h00,8'h00,8'h00,4'd6},  // clear bit 3
    {1'b1,1'b1,2'd2,8'h00,8'h00,8'h00,8'h80,4'd6},  // R6
    {1'b1,1'b1,2'd3,8'h00,8'h00,8'h00,8'h80,4'd6},  // R6 cfg untouched
    {1'b0,1'b1,2'd0,8'h77,8'h00,8'h00,8'h77,4'd7},  // R7
    {1'b0,1'b0,2'd3,8'h80,8'h00,8'h00,8'h00,4'd7},  // reconfigure
    {1'b1,1'b1,2'd0,8'h00,8'h00,8'h00,8'h00,4'd7},  // R7 A cleared
    {1'b1,1'b1,2'd2,8'h00,8'h00,8'h00,8'h00,4'd7}   // R7 C cleared
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
    v = rdata;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog R1..: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pa_oe", pa_oe, 8'h00);
    check("R1 pb_oe", pb_oe, 8'h00);
    check("R1 pc_oe", pc_oe, 8'h00);
    check("R1 pa_out", pa_out, 8'h00);
    check("R1 rdata", rdata, 8'h00);
    bus_rd(2'd3, v);
    check("R1 ctrl", v, 8'h9B);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [39:0] e;
      logic [7:0]  act;
      string       tag;
      e = VEC[i];
      @(negedge clk);
      cs = 1'b1; addr = e[37:36]; wdata = e[35:28];
      pa_in = e[27:20]; pb_in = e[27:20]; pc_in = e[19:12];
      rd = e[39]; wr = ~e[39];
      @(negedge clk);
      cs = 1'b0; rd = 1'b0; wr = 1'b0;
      if (e[38]) begin
        if (e[39])               act = rdata;
        else if (e[37:36] == 2'd0) act = pa_out;
        else if (e[37:36] == 2'd1) act = pb_out;
        else                       act = pc_out;
        tag = $sformatf("R%0d vec %0d", e[3:0], i);
        check(tag, act, e[11:4]);
      end
    end

    // R12 deselected write ignored
    bus_wr(2'd0, 8'h11);
    @(negedge clk);
    wr = 1'b1; addr = 2'd0; wdata = 8'hEE;
    @(negedge clk);
    wr = 1'b0;
    check("R12 pa_out", pa_out, 8'h11);

    // R8 group A handshake input
    pc_in = 8'hFF;
    bus_wr(2'd3, 8'hB0);
    check("R11 pc_oe A in", pc_oe, 8'hEF);
    check("R8 ibf idle", {7'd0, pc_out[5]}, 8'h00);
    pa_in = 8'h3E; pc_in[4] = 1'b0;
    @(negedge clk);
    check("R8 ibf set", {7'd0, pc_out[5]}, 8'h01);
    check("R8 intr low", {7'd0, pc_out[3]}, 8'h00);
    pa_in = 8'h00; pc_in[4] = 1'b1;
    @(negedge clk);
    check("R8 intr on rise", {7'd0, pc_out[3]}, 8'h01);
    bus_rd(2'd0, v);
    check("R8 latched data", v, 8'h3E);
    check("R8 flags cleared", {6'd0, pc_out[5], pc_out[3]}, 8'h00);

    // R9 group A handshake output
    bus_wr(2'd3, 8'hA0);
    check("R11 pc_oe A out", pc_oe, 8'hBF);
    check("R9 obf idle", {7'd0, pc_out[7]}, 8'h01);
    bus_wr(2'd0, 8'h5C);
    check("R9 obf low", {7'd0, pc_out[7]}, 8'h00);
    check("R9 data", pa_out, 8'h5C);
    pc_in[6] = 1'b0;
    @(negedge clk);
    check("R9 obf on ack", {6'd0, pc_out[7], pc_out[3]}, 8'h02);
    pc_in[6] = 1'b1;
    @(negedge clk);
    check("R9 intr on ack rise", {7'd0, pc_out[3]}, 8'h01);
    bus_wr(2'd0, 8'h12);
    check("R9 intr cleared", {6'd0, pc_out[7], pc_out[3]}, 8'h00);

    // R10 group B handshake input then output
    bus_wr(2'd3, 8'h86);
    check("R11 pc_oe B in", pc_oe[2:0], 3'b011);
    pb_in = 8'hA7; pc_in[2] = 1'b0;
    @(negedge clk);
    check("R10 ibf", {6'd0, pc_out[1:0]}, 8'h02);
    pb_in = 8'h00; pc_in[2] = 1'b1;
    @(negedge clk);
    check("R10 intr", {6'd0, pc_out[1:0]}, 8'h03);
    bus_rd(2'd1, v);
    check("R10 data", v, 8'hA7);
    check("R10 cleared", {6'd0, pc_out[1:0]}, 8'h00);
    bus_wr(2'd3, 8'h84);
    bus_wr(2'd1, 8'h3A);
    check("R10 obf low", {6'd0, pc_out[1:0]}, 8'h00);
    pc_in[2] = 1'b0;
    @(negedge clk);
    check("R10 obf on ack", {6'd0, pc_out[1:0]}, 8'h02);
    pc_in[2] = 1'b1;
    @(negedge clk);
    check("R10 intr on ack rise", {6'd0, pc_out[1:0]}, 8'h03);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule